// File: doc/BRIEF.md
# Full-duplex stereo audio serial port (clock master)

This block is a stereo audio serial port that always acts as clock master. It divides its own clock to make a bit clock and derives a frame (word-select) clock from a bit counter. It shifts a pair of transmit samples out on a serial data line and assembles the samples arriving on a serial data input into a received pair. Every frame has 64 bit-clock slots, two slots of 32 per channel. The sample sits inside its slot according to the selected framing: standard I2S, left-justified, right-justified or PCM.

A static configuration word sets the framing, the sample length, the polarity of both clocks, channel swapping for each direction on its own, and a mono mode. Transmit pairs enter through a one-deep buffer with a valid/ready handshake. Received pairs leave as right-aligned 32-bit words, flagged by a one-cycle valid pulse. The configuration word and divider may change only while reset is held.

Top module: `audio_serial_port`

## Requirements
- R1: The bit clock has a period of 2*(clk_div+1) clock cycles. `cfg_word[4]` = 1 inverts it. In reset `bclk_o` equals `1 ^ cfg_word[4]`, `ws_o` equals `cfg_word[5]`, `sdout_o` is 0, `tx_ready` is 1, and `rx_valid` and `tx_underrun` are 0.
- R2: A frame is 64 bit-clock slots, and the first falling edge after reset opens slot 0. In the right-justified, left-justified and I2S formats the un-inverted word select is low (left) in slots 0..31 and high (right) in slots 32..63. In PCM it is high in slot 0 only. `cfg_word[5]` = 1 inverts word select.
- R3: `cfg_word[1:0]` picks the framing: 00 right-justified, 01 left-justified, 10 standard I2S, 11 PCM. In left-justified mode the MSB of each channel is in the channel's first slot (0 or 32). In I2S mode every bit comes one slot later, so the right LSB of a 32-bit word lands in slot 0 of the next frame.
- R4: In right-justified mode the LSB is in slot 31 (left) or 63 (right). A 32-bit length in this mode is treated as 24 bits.
- R5: In PCM mode the left MSB is in slot 0, and the right word follows the left LSB directly. Slots after the right LSB carry 0.
- R6: `cfg_word[3:2]` sets the sample length: 00 = 16, 01 = 20, 10 = 24, 11 = 32 bits. Slots outside the sample carry 0. Received words are right-aligned with upper bits 0.
- R7: Data and word select change only on a falling edge of the un-inverted bit clock, and `sdin_i` is sampled on its rising edge.
- R8: A transmit pair is accepted when `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low until the buffered pair moves into the shifter at the start of the next frame. Consecutive frames carry consecutive accepted pairs.
- R9: If the buffer is empty at a frame start, the frame carries zeros and `tx_underrun` is set. It stays set until reset.
- R10: `cfg_word[6]` = 1 swaps which transmit word goes in the left and right slots.
- R11: After the last bit of each frame, `rx_valid` pulses for one cycle with that frame's pair. The partial frame after reset is not reported. `cfg_word[7]` = 1 swaps the received slots onto the outputs.
- R12: `cfg_word[8]` = 1 selects mono. `tx_left` goes in the left slot, the right slot carries zeros, and both swap bits are ignored. `rx_left` comes from the left slot and `rx_right` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 9 | Static configuration: format, length, polarities, swaps, mono |
| clk_div | input | DIV_W | Bit-clock half period minus one, in clk cycles |
| tx_left | input | 32 | Left transmit sample, right-aligned |
| tx_right | input | 32 | Right transmit sample, right-aligned |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Transmit buffer empty |
| rx_left | output | 32 | Received left sample |
| rx_right | output | 32 | Received right sample |
| rx_valid | output | 1 | One-cycle pulse: new received pair |
| tx_underrun | output | 1 | Sticky: a frame went out without data |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Frame / word-select clock |
| sdout_o | output | 1 | Serial data out |
| sdin_i | input | 1 | Serial data in |

## Verification
The hardest case to reach is the I2S frame wrap. There, a 32-bit right word ends in slot 0 of the following frame, and the received pair may be published only after that bit arrives. The bench runs a sweep in which every format meets every sample length, and each run takes several frames in a row. The expected stream is indexed by slot count since reset, so the wrapped bit is compared in both directions. The polarity, swap and mono bits change from run to run, so each of them is seen against several framings.

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [8:0]       cfg_word,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [31:0]      tx_left,
  input  logic [31:0]      tx_right,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [31:0]      rx_left,
  output logic [31:0]      rx_right,
  output logic             rx_valid,
  output logic             tx_underrun,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             sdout_o,
  input  logic             sdin_i
);
  localparam int SLOT_LOG = 6;

  logic [1:0] fmt;
  logic [1:0] wlen;
  logic       bc_inv, fs_inv, tx_swap, rx_swap, mono;
  assign fmt     = cfg_word[1:0];
  assign wlen    = cfg_word[3:2];
  assign bc_inv  = cfg_word[4];
  assign fs_inv  = cfg_word[5];
  assign tx_swap = cfg_word[6];
  assign rx_swap = cfg_word[7];
  assign mono    = cfg_word[8];

  logic [6:0] wbits;
  always_comb begin
    case (wlen)
      2'b00:   wbits = 7'd16;
      2'b01:   wbits = 7'd20;
      2'b10:   wbits = 7'd24;
      default: wbits = (fmt == 2'b00) ? 7'd24 : 7'd32;
    endcase
  end

  logic [SLOT_LOG-1:0] dly;
  assign dly = {5'd0, fmt == 2'b10};

  function automatic logic [6:0] slot_map(input logic [5:0] s, input logic [1:0] f,
                                          input logic [6:0] w, input logic [5:0] dl);
    logic [5:0] d;
    logic [6:0] dd, pp, ix;
    logic v, c;
    d  = s - dl;
    dd = {1'b0, d};
    pp = {2'b00, d[4:0]};
    v  = 1'b0;
    c  = 1'b0;
    ix = '0;
    if (f == 2'b11) begin
      if (dd < w) begin
        v = 1'b1; ix = w - 7'd1 - dd;
      end else if (dd < {w[5:0], 1'b0}) begin
        v = 1'b1; c = 1'b1; ix = {w[5:0], 1'b0} - 7'd1 - dd;
      end
    end else begin
      c = d[5];
      if (f == 2'b00) begin
        if (pp >= 7'd32 - w) begin v = 1'b1; ix = 7'd31 - pp; end
      end else if (pp < w) begin
        v = 1'b1; ix = w - 7'd1 - pp;
      end
    end
    return {v, c, ix[4:0]};
  endfunction

  logic [DIV_W-1:0]    cnt;
  logic                bclk_q, ws_q, sd_q;
  logic [SLOT_LOG-1:0] slot;
  logic [31:0]         buf_l, buf_r, cur_l, cur_r, acc_l, acc_r;
  logic                buf_full, started;

  logic tick, fall, rise, load;
  logic [SLOT_LOG-1:0] nslot;
  assign tick  = (cnt == clk_div);
  assign fall  = tick & bclk_q;
  assign rise  = tick & ~bclk_q;
  assign nslot = slot + 6'd1;
  assign load  = fall & (nslot == dly);

  logic [31:0] new_l, new_r, nxt_l, nxt_r;
  assign new_l = !buf_full ? 32'd0 : ((tx_swap & ~mono) ? buf_r : buf_l);
  assign new_r = (!buf_full || mono) ? 32'd0 : (tx_swap ? buf_l : buf_r);
  assign nxt_l = load ? new_l : cur_l;
  assign nxt_r = load ? new_r : cur_r;

  logic [6:0] tmap, rmap;
  logic       tx_bit, ws_next;
  assign tmap    = slot_map(nslot, fmt, wbits, dly);
  assign rmap    = slot_map(slot, fmt, wbits, dly);
  assign tx_bit  = tmap[6] & (tmap[5] ? nxt_r[tmap[4:0]] : nxt_l[tmap[4:0]]);
  assign ws_next = (fmt == 2'b11) ? (nslot == 6'd0) : nslot[5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      bclk_q      <= 1'b1;
      slot        <= '1;
      ws_q        <= 1'b0;
      sd_q        <= 1'b0;
      buf_l       <= '0;
      buf_r       <= '0;
      buf_full    <= 1'b0;
      cur_l       <= '0;
      cur_r       <= '0;
      acc_l       <= '0;
      acc_r       <= '0;
      started     <= 1'b0;
      rx_left     <= '0;
      rx_right    <= '0;
      rx_valid    <= 1'b0;
      tx_underrun <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      cnt      <= tick ? '0 : cnt + 1'b1;
      if (tick) bclk_q <= ~bclk_q;
      if (tx_valid && !buf_full) begin
        buf_l    <= tx_left;
        buf_r    <= tx_right;
        buf_full <= 1'b1;
      end
      if (fall) begin
        slot <= nslot;
        ws_q <= ws_next;
        sd_q <= tx_bit;
      end
      if (load) begin
        cur_l <= new_l;
        cur_r <= new_r;
        if (buf_full) buf_full <= 1'b0;
        else          tx_underrun <= 1'b1;
        if (started) begin
          rx_left  <= (rx_swap & ~mono) ? acc_r : acc_l;
          rx_right <= mono ? 32'd0 : (rx_swap ? acc_l : acc_r);
          rx_valid <= 1'b1;
        end
        started <= 1'b1;
        acc_l   <= '0;
        acc_r   <= '0;
      end
      if (rise && rmap[6]) begin
        if (rmap[5]) acc_r[rmap[4:0]] <= sdin_i;
        else         acc_l[rmap[4:0]] <= sdin_i;
      end
    end
  end

  assign tx_ready = ~buf_full;
  assign bclk_o   = bclk_q ^ bc_inv;
  assign ws_o     = ws_q ^ fs_inv;
  assign sdout_o  = sd_q;
endmodule

// File: rtl/audio_serial_port_chk.sv
module audio_serial_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [8:0]  cfg_word,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        rx_valid,
  input logic [31:0] rx_right,
  input logic        tx_underrun,
  input logic        bclk_o,
  input logic        ws_o,
  input logic        sdout_o
);
  a_r11_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> tx_underrun);

  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r7_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout_o) |-> (!$stable(bclk_o) && ((bclk_o ^ cfg_word[4]) == 1'b0)));

  a_r2_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws_o) |-> (!$stable(bclk_o) && ((bclk_o ^ cfg_word[4]) == 1'b0)));

  a_r12_mono_right_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_word[8]) |-> (rx_right == 32'd0));
endmodule

bind audio_serial_port audio_serial_port_chk chk_i (.*);

// File: tb/audio_serial_port_tb_top.sv
module audio_serial_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  cfg_word = '0;
  logic [7:0]  clk_div = 8'd1;
  logic [31:0] tx_left = '0, tx_right = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, rx_valid, tx_underrun, bclk_o, ws_o, sdout_o;
  logic [31:0] rx_left, rx_right;
  logic        sdin_i = 1'b0;

  always #4 clk = ~clk;

  audio_serial_port #(.DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .clk_div(clk_div),
    .tx_left(tx_left), .tx_right(tx_right), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid), .tx_underrun(tx_underrun),
    .bclk_o(bclk_o), .ws_o(ws_o), .sdout_o(sdout_o), .sdin_i(sdin_i));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pl(input int n); return 32'h8000_0001 ^ (n * 32'h9E37_79B9) ^ 32'h0F0F_1234; endfunction
  function automatic logic [31:0] pr(input int n); return 32'hC5A5_0F81 ^ (n * 32'h7F4A_7C15); endfunction
  function automatic logic [31:0] ql(input int n); return 32'hB3D1_0A67 ^ (n * 32'h6A09_E667); endfunction
  function automatic logic [31:0] qr(input int n); return 32'h91E1_5C2B ^ (n * 32'h3C6E_F372); endfunction

  function automatic int eff_w(input int f, input int wl);
    int w;
    w = (wl == 0) ? 16 : (wl == 1) ? 20 : (wl == 2) ? 24 : 32;
    if (f == 0 && w == 32) w = 24;
    return w;
  endfunction

  function automatic logic [31:0] wmask(input int w);
    return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
  endfunction

  function automatic logic exp_bit(input logic [31:0] l, input logic [31:0] r, input int d,
                                   input int f, input int w);
    logic [31:0] word;
    int p;
    if (f == 3) begin
      if (d < w) return l[w-1-d];
      if (d < 2*w) return r[2*w-1-d];
      return 1'b0;
    end
    p = d % 32;
    word = (d >= 32) ? r : l;
    if (f == 0) return (p >= 32 - w) ? word[31-p] : 1'b0;
    return (p < w) ? word[w-1-p] : 1'b0;
  endfunction

  int   fmt_i, w_i, dly_i, div_i;
  bit   bci, fsi, txs, rxs, mono, tx_on, mon_en;
  int   rise_cnt, fall_cnt, rx_cnt, tx_cnt, since_rise;
  bit   prev_b, pend;

  always @(negedge clk) begin
    if (mon_en) begin
      logic nb, ews, ebit;
      logic [31:0] sl, sr, el, er;
      int k, d, n;
      nb = bclk_o ^ bci;
      since_rise++;
      if (pend) begin
        tx_cnt++;
        tx_left  = pl(tx_cnt);
        tx_right = pr(tx_cnt);
      end
      pend = tx_valid && tx_ready;
      if (nb && !prev_b) begin
        k = rise_cnt;
        ews = (fmt_i == 3) ? ((k % 64) == 0) : ((k % 64) >= 32);
        chk(ws_o == (ews ^ fsi), "R2 word select", {31'd0, ws_o}, {31'd0, ews ^ fsi});
        ebit = 1'b0;
        if (k >= dly_i && tx_on) begin
          n = (k - dly_i) / 64;
          d = (k - dly_i) % 64;
          sl = mono ? pl(n) : (txs ? pr(n) : pl(n));
          sr = mono ? 32'd0 : (txs ? pl(n) : pr(n));
          ebit = exp_bit(sl, sr, d, fmt_i, w_i);
        end
        chk(sdout_o == ebit, "R3 R4 R5 R6 R10 R12 serial data", {31'd0, sdout_o}, {31'd0, ebit});
        if (rise_cnt > 0)
          chk(since_rise == 2 * (div_i + 1), "R1 bit clock period", since_rise, 2 * (div_i + 1));
        since_rise = 0;
        rise_cnt++;
      end
      if (!nb && prev_b) begin
        k = fall_cnt;
        sdin_i = 1'b0;
        if (k >= dly_i) begin
          n = (k - dly_i) / 64;
          d = (k - dly_i) % 64;
          sdin_i = exp_bit(ql(n), qr(n), d, fmt_i, w_i);
        end
        fall_cnt++;
      end
      if (rx_valid) begin
        el = mono ? (ql(rx_cnt) & wmask(w_i)) : ((rxs ? qr(rx_cnt) : ql(rx_cnt)) & wmask(w_i));
        er = mono ? 32'd0 : ((rxs ? ql(rx_cnt) : qr(rx_cnt)) & wmask(w_i));
        chk(rx_left == el, "R11 R6 received left", rx_left, el);
        chk(rx_right == er, "R11 R12 received right", rx_right, er);
        rx_cnt++;
      end
      prev_b = nb;
    end
  end

  task automatic run_cfg(input int f, input int wl, input int flags, input int dv, input bit feed);
    mon_en = 1'b0;
    @(posedge clk) #1;
    rst_n = 1'b0;
    fmt_i = f; w_i = eff_w(f, wl); dly_i = (f == 2) ? 1 : 0; div_i = dv;
    bci = flags[0]; fsi = flags[1]; txs = flags[2]; rxs = flags[3]; mono = flags[4];
    tx_on = feed;
    cfg_word = {mono, rxs, txs, fsi, bci, wl[1:0], f[1:0]};
    clk_div = dv[7:0];
    tx_cnt = 0; tx_left = pl(0); tx_right = pr(0); tx_valid = feed;
    rise_cnt = 0; fall_cnt = 0; rx_cnt = 0; since_rise = 0; prev_b = 1'b1; pend = 1'b0;
    sdin_i = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    chk(bclk_o == (1'b1 ^ bci) && ws_o == fsi && sdout_o == 1'b0, "R1 reset lines",
        {29'd0, bclk_o, ws_o, sdout_o}, {29'd0, 1'b1 ^ bci, fsi, 1'b0});
    chk(tx_ready && !rx_valid && !tx_underrun, "R1 reset flags",
        {29'd0, tx_ready, rx_valid, tx_underrun}, 32'd4);
    @(posedge clk) #1;
    rst_n = 1'b1;
    mon_en = 1'b1;
    wait (fall_cnt >= 64 * 4 + 2);
    @(negedge clk);
    #1;
    chk(rx_cnt == 4, "R11 pairs reported", rx_cnt, 4);
    if (feed) begin
      chk(tx_underrun == 1'b0, "R9 no underrun when fed", {31'd0, tx_underrun}, 32'd0);
      chk(tx_cnt >= 4, "R8 pairs accepted", tx_cnt, 4);
    end else begin
      chk(tx_underrun == 1'b1, "R9 underrun sticky", {31'd0, tx_underrun}, 32'd1);
      chk(tx_ready == 1'b1, "R8 ready while empty", {31'd0, tx_ready}, 32'd1);
    end
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    mon_en = 1'b0;
    for (int i = 0; i < 32; i++)
      run_cfg(i % 4, (i / 4) % 4, (i * 13 + 5) % 32, 1 + (i % 2), 1'b1);
    run_cfg(2, 0, 0, 1, 1'b1);
    run_cfg(1, 0, 4, 1, 1'b0);
    run_cfg(3, 3, 16, 1, 1'b0);
    mon_en = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule